// File: doc/BRIEF.md
# Host–Firmware Mailbox with Ownership Lock

This block is a register-mapped mailbox shared by a host function and an embedded firmware agent. Each side has its own simple 32-bit register port that reaches a small shared message memory, a control register, two sequence-counter registers and an interrupt mask. One ownership lock protects the message memory.

A side claims the lock by writing the lock bit into its control register. It then reads that register back and owns the mailbox only if the bit reads as set. A single control write clears the lock and raises the request bit, which releases the mailbox and posts a message in one step. The receiver reads the message and writes memory word 0 last. That write tells the hardware the message was consumed, and the hardware drops the sender's request bit.

Each counter register holds a request count in bits [15:0] and an acknowledge count in bits [31:16]. Software detects new traffic by comparing the peer's counter with the last value it saw. A counter of zero marks a reset mailbox. The block sends a one-cycle interrupt to the opposite side when a request bit rises or a counter changes, unless the matching mask bit is set.

Top module: `mbx_top`

## Requirements
- R1: After reset, every register and memory word reads zero from both ports, no side owns the lock, and both interrupt outputs are low.
- R2: A control write with bit 0 (lock) set while the mailbox is free gives ownership to the writer. From the next cycle the writer reads bit 0 of its control register as 1, and the peer reads it as 0.
- R3: When both sides write the lock bit in the same cycle to a free mailbox, the host wins. The firmware then reads its lock bit as 0.
- R4: A lock write from the side that does not own the mailbox is ignored, whether it sets or clears the bit. Only the owner can clear the lock.
- R5: A control write of value 2 from the owner (bit 0 clear, bit 1 request set) releases the lock and sets that side's request bit in the same cycle. Bit 2 of each control register shows the peer's request bit.
- R6: The host counter register is at word address MEM_WORDS+1 and only the host can write it. The firmware counter register is at MEM_WORDS+2 and only the firmware can write it. Both sides can read both counters, and writes from the other side are ignored.
- R7: Word addresses 0 to MEM_WORDS-1 are shared memory that either side can read and write. If both sides write the same word in one cycle, the host write is kept.
- R8: A write to memory word 0 clears the request bit of the opposite side.
- R9: fwIrq is high for one cycle, the cycle after the write, when a host control write raises the host request bit with mask bit 0 clear. It is also high when a host counter write changes the stored value with mask bit 1 clear.
- R10: hostIrq is high for one cycle after the same firmware-side events, gated by mask bits 16 (request) and 17 (counter).
- R11: The mask register at word address MEM_WORDS+3 is written only by the host and resets to zero. A firmware write to it is ignored. Mask writes and memory writes never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hSel | input | 1 | Host port access strobe |
| hWr | input | 1 | Host write enable (with hSel) |
| hAddr | input | ADDR_W | Host word address |
| hWdata | input | 32 | Host write data |
| hRdata | output | 32 | Host read data, combinational from hAddr |
| fSel | input | 1 | Firmware port access strobe |
| fWr | input | 1 | Firmware write enable (with fSel) |
| fAddr | input | ADDR_W | Firmware word address |
| fWdata | input | 32 | Firmware write data |
| fRdata | output | 32 | Firmware read data, combinational from fAddr |
| fwIrq | output | 1 | Notification pulse to firmware |
| hostIrq | output | 1 | Notification pulse to host |

## Verification
The bound checker watches the lock on every cycle. It confirms that the owner keeps the lock unless it writes a clear, that a free mailbox goes to the first claimer and to the host on a tie, and that an owner's release-with-request write frees the lock. It also confirms that every interrupt pulse follows a write from the opposite port. The bench scenarios are the only place where read-back values appear: memory and counter contents, the peer request bit, request clearing by a word-0 write, the effect of each mask bit, and counter writes of an unchanged value that must stay silent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_FW   = 2'd2
  } owner_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWrH;
    logic memWrF;
    logic cntWrH;
    logic cntWrF;
    logic maskWr;
    logic ctrlWrH;
    logic ctrlWrF;
    logic ownHost;
    logic ownFw;
  } strobe_t;

  localparam int LOCK_BIT     = 0;
  localparam int REQ_BIT      = 1;
  localparam int PEER_REQ_BIT = 2;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int MEM_WORDS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSel,
  input  logic              hWr,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic              hLock,
  input  logic              fSel,
  input  logic              fWr,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic              fLock,
  output strobe_t           str
);
  localparam int CTRL_A = MEM_WORDS;
  localparam int HCNT_A = MEM_WORDS + 1;
  localparam int FCNT_A = MEM_WORDS + 2;
  localparam int MASK_A = MEM_WORDS + 3;

  owner_t owner, ownerNext;
  logic hWe, fWe, hCtrl, fCtrl;

  assign hWe   = hSel && hWr;
  assign fWe   = fSel && fWr;
  assign hCtrl = hWe && (hAddr == ADDR_W'(CTRL_A));
  assign fCtrl = fWe && (fAddr == ADDR_W'(CTRL_A));

  // Lock arbitration: host has fixed priority on a tie
  always_comb begin
    ownerNext = owner;
    case (owner)
      OWN_NONE: begin
        if (hCtrl && hLock)      ownerNext = OWN_HOST;
        else if (fCtrl && fLock) ownerNext = OWN_FW;
      end
      OWN_HOST: if (hCtrl && !hLock) ownerNext = OWN_NONE;
      OWN_FW:   if (fCtrl && !fLock) ownerNext = OWN_NONE;
      default:  ownerNext = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  always_comb begin
    str.memWrH  = hWe && (hAddr < ADDR_W'(MEM_WORDS));
    str.memWrF  = fWe && (fAddr < ADDR_W'(MEM_WORDS));
    str.cntWrH  = hWe && (hAddr == ADDR_W'(HCNT_A));
    str.cntWrF  = fWe && (fAddr == ADDR_W'(FCNT_A));
    str.maskWr  = hWe && (hAddr == ADDR_W'(MASK_A));
    str.ctrlWrH = hCtrl;
    str.ctrlWrF = fCtrl;
    str.ownHost = (owner == OWN_HOST);
    str.ownFw   = (owner == OWN_FW);
  end
endmodule

// File: rtl/mbx_dp.sv
module mbx_dp
  import mbx_pkg::*;
#(
  parameter int MEM_WORDS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [31:0]       hWdata,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic [31:0]       fWdata,
  output logic [31:0]       hRdata,
  output logic [31:0]       fRdata,
  output logic              fwIrq,
  output logic              hostIrq
);
  localparam int IDX_W  = $clog2(MEM_WORDS);
  localparam int CTRL_A = MEM_WORDS;
  localparam int HCNT_A = MEM_WORDS + 1;
  localparam int FCNT_A = MEM_WORDS + 2;
  localparam int MASK_A = MEM_WORDS + 3;

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] hostCnt, fwCnt, mask;
  logic        reqHost, reqFw;
  logic [IDX_W-1:0] hIdx, fIdx;
  logic hostReqRise, fwReqRise, hostCntChg, fwCntChg;
  logic hWord0, fWord0;

  assign hIdx   = hAddr[IDX_W-1:0];
  assign fIdx   = fAddr[IDX_W-1:0];
  assign hWord0 = str.memWrH && (hIdx == '0);
  assign fWord0 = str.memWrF && (fIdx == '0);

  assign hostReqRise = str.ctrlWrH && hWdata[REQ_BIT] && !reqHost;
  assign fwReqRise   = str.ctrlWrF && fWdata[REQ_BIT] && !reqFw;
  assign hostCntChg  = str.cntWrH && (hWdata != hostCnt);
  assign fwCntChg    = str.cntWrF && (fWdata != fwCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
      hostCnt <= '0;
      fwCnt   <= '0;
      mask    <= '0;
      reqHost <= 1'b0;
      reqFw   <= 1'b0;
      fwIrq   <= 1'b0;
      hostIrq <= 1'b0;
    end else begin
      // host write placed last so it wins a same-word collision
      if (str.memWrF) mem[fIdx] <= fWdata;
      if (str.memWrH) mem[hIdx] <= hWdata;
      if (str.cntWrH) hostCnt <= hWdata;
      if (str.cntWrF) fwCnt   <= fWdata;
      if (str.maskWr) mask    <= hWdata;
      // own control write takes precedence over the peer's word-0 consume
      if (str.ctrlWrH)  reqHost <= hWdata[REQ_BIT];
      else if (fWord0)  reqHost <= 1'b0;
      if (str.ctrlWrF)  reqFw   <= fWdata[REQ_BIT];
      else if (hWord0)  reqFw   <= 1'b0;
      fwIrq   <= (hostReqRise && !mask[0])  || (hostCntChg && !mask[1]);
      hostIrq <= (fwReqRise   && !mask[16]) || (fwCntChg   && !mask[17]);
    end
  end

  function automatic logic [31:0] rdMux(input logic [ADDR_W-1:0] a,
                                        input logic own, input logic myReq,
                                        input logic peerReq);
    logic [31:0] r;
    r = '0;
    if (a < ADDR_W'(MEM_WORDS)) r = mem[a[IDX_W-1:0]];
    else if (a == ADDR_W'(CTRL_A)) begin
      r[LOCK_BIT]     = own;
      r[REQ_BIT]      = myReq;
      r[PEER_REQ_BIT] = peerReq;
    end
    else if (a == ADDR_W'(HCNT_A)) r = hostCnt;
    else if (a == ADDR_W'(FCNT_A)) r = fwCnt;
    else if (a == ADDR_W'(MASK_A)) r = mask;
    return r;
  endfunction

  assign hRdata = rdMux(hAddr, str.ownHost, reqHost, reqFw);
  assign fRdata = rdMux(fAddr, str.ownFw, reqFw, reqHost);
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int MEM_WORDS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSel,
  input  logic              hWr,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [31:0]       hWdata,
  output logic [31:0]       hRdata,
  input  logic              fSel,
  input  logic              fWr,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic [31:0]       fWdata,
  output logic [31:0]       fRdata,
  output logic              fwIrq,
  output logic              hostIrq
);
  strobe_t str;

  mbx_ctrl #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hSel(hSel), .hWr(hWr), .hAddr(hAddr), .hLock(hWdata[LOCK_BIT]),
    .fSel(fSel), .fWr(fWr), .fAddr(fAddr), .fLock(fWdata[LOCK_BIT]),
    .str(str)
  );

  mbx_dp #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .str(str),
    .hAddr(hAddr), .hWdata(hWdata), .fAddr(fAddr), .fWdata(fWdata),
    .hRdata(hRdata), .fRdata(fRdata), .fwIrq(fwIrq), .hostIrq(hostIrq)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int MEM_WORDS = 8,
  parameter int ADDR_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hSel,
  input logic              hWr,
  input logic [ADDR_W-1:0] hAddr,
  input logic [31:0]       hWdata,
  input logic              fSel,
  input logic              fWr,
  input logic [ADDR_W-1:0] fAddr,
  input logic [31:0]       fWdata,
  input logic              ownHost,
  input logic              ownFw,
  input logic              fwIrq,
  input logic              hostIrq
);
  localparam int CTRL_A = MEM_WORDS;
  logic hCtl, fCtl, isFree;
  assign hCtl   = hSel && hWr && (hAddr == ADDR_W'(CTRL_A));
  assign fCtl   = fSel && fWr && (fAddr == ADDR_W'(CTRL_A));
  assign isFree = !ownHost && !ownFw;

  AST_CLAIM_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (isFree && hCtl && hWdata[0]) |=> ownHost); // R2
  AST_TIE_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (isFree && hCtl && hWdata[0] && fCtl && fWdata[0]) |=> (ownHost && !ownFw)); // R3
  AST_HOST_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ownHost && !(hCtl && !hWdata[0])) |=> ownHost); // R4
  AST_FW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ownFw && !(fCtl && !fWdata[0])) |=> ownFw); // R4
  AST_RELEASE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (ownHost && hCtl && hWdata[1:0] == 2'b10) |=> !ownHost); // R5
  AST_FWIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    fwIrq |-> $past(hSel && hWr)); // R9
  AST_HOSTIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(fSel && fWr)); // R10
endmodule

bind mbx_top mbx_chk #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .hSel(hSel), .hWr(hWr), .hAddr(hAddr), .hWdata(hWdata),
  .fSel(fSel), .fWr(fWr), .fAddr(fAddr), .fWdata(fWdata),
  .ownHost(str.ownHost), .ownFw(str.ownFw),
  .fwIrq(fwIrq), .hostIrq(hostIrq)
);

// File: tb/mbx_top_tb_top.sv
module mbx_top_tb_top;
  localparam int MEM_WORDS = 8;
  localparam int ADDR_W    = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(MEM_WORDS);
  localparam logic [ADDR_W-1:0] A_HCNT = ADDR_W'(MEM_WORDS + 1);
  localparam logic [ADDR_W-1:0] A_FCNT = ADDR_W'(MEM_WORDS + 2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MEM_WORDS + 3);

  logic clk = 1'b0, rstN = 1'b0;
  logic hSel = 0, hWr = 0, fSel = 0, fWr = 0;
  logic [ADDR_W-1:0] hAddr = '0, fAddr = '0;
  logic [31:0] hWdata = '0, fWdata = '0, hRdata, fRdata;
  logic fwIrq, hostIrq;
  int checks = 0, fails = 0;
  logic lastFwIrq, lastHostIrq;
  logic [31:0] memModel [MEM_WORDS];
  logic [31:0] hcntModel = '0, fcntModel = '0, maskModel = '0;

  always #10 clk = ~clk;

  mbx_top #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .hSel(hSel), .hWr(hWr), .hAddr(hAddr), .hWdata(hWdata), .hRdata(hRdata),
    .fSel(fSel), .fWr(fWr), .fAddr(fAddr), .fWdata(fWdata), .fRdata(fRdata),
    .fwIrq(fwIrq), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expCntIrq(input logic [31:0] oldV, input logic [31:0] newV,
                                     input logic maskBit);
    return (oldV != newV) && !maskBit;
  endfunction

  task automatic bothWrite(input logic hEn, input logic [ADDR_W-1:0] ha, input logic [31:0] hd,
                           input logic fEn, input logic [ADDR_W-1:0] fa, input logic [31:0] fd);
    @(negedge clk);
    hSel = hEn; hWr = hEn; hAddr = ha; hWdata = hd;
    fSel = fEn; fWr = fEn; fAddr = fa; fWdata = fd;
    @(negedge clk);
    lastFwIrq = fwIrq; lastHostIrq = hostIrq;
    hSel = 0; hWr = 0; fSel = 0; fWr = 0;
  endtask

  task automatic hWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bothWrite(1'b1, a, d, 1'b0, '0, '0);
  endtask

  task automatic fWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bothWrite(1'b0, '0, '0, 1'b1, a, d);
  endtask

  task automatic hRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); hAddr = a; #1; d = hRdata;
  endtask

  task automatic fRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); fAddr = a; #1; d = fRdata;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < MEM_WORDS; i++) memModel[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < MEM_WORDS + 4; a++) begin
      hRead(ADDR_W'(a), d); check("R1 host read after reset", d, 32'h0);
      fRead(ADDR_W'(a), d); check("R1 fw read after reset", d, 32'h0);
    end
    check("R1 irqs low after reset", {30'h0, fwIrq, hostIrq}, 32'h0);

    // R2 host claims a free mailbox
    hWrite(A_CTRL, 32'h1);
    hRead(A_CTRL, d); check("R2 host lock bit", d, 32'h1);
    fRead(A_CTRL, d); check("R2 fw sees no lock", d, 32'h0);

    // R4 non-owner set and clear are ignored
    fWrite(A_CTRL, 32'h1);
    fRead(A_CTRL, d); check("R4 fw claim ignored", d & 32'h1, 32'h0);
    fWrite(A_CTRL, 32'h0);
    hRead(A_CTRL, d); check("R4 host keeps lock after fw clear", d & 32'h1, 32'h1);

    // R7 message memory host to fw
    for (int i = 0; i < MEM_WORDS; i++) begin
      memModel[i] = $urandom;
      hWrite(ADDR_W'(i), memModel[i]);
      check("R11 memory write raises no fwIrq", {31'h0, lastFwIrq}, 32'h0);
    end
    for (int i = 0; i < MEM_WORDS; i++) begin
      fRead(ADDR_W'(i), d); check("R7 fw reads host message", d, memModel[i]);
    end

    // R6 and R9 host counter
    hWrite(A_HCNT, 32'h0000_0001); hcntModel = 32'h1;
    check("R9 fwIrq on host counter change", {31'h0, lastFwIrq}, 32'h1);
    fWrite(A_HCNT, 32'hDEAD_BEEF);
    fRead(A_HCNT, d); check("R6 fw write to host counter ignored", d, 32'h1);
    hWrite(A_HCNT, 32'h0000_0001);
    check("R9 no fwIrq on unchanged counter", {31'h0, lastFwIrq}, 32'h0);

    // R5 release with request in one write
    hWrite(A_CTRL, 32'h2);
    check("R9 fwIrq on request rise", {31'h0, lastFwIrq}, 32'h1);
    hRead(A_CTRL, d); check("R5 host released with request", d, 32'h2);
    fRead(A_CTRL, d); check("R5 fw sees peer request", d, 32'h4);

    // R8 fw claims, consumes, writes word 0 last
    fWrite(A_CTRL, 32'h1);
    fRead(A_CTRL, d); check("R2 fw lock bit", d, 32'h5);
    fWrite(ADDR_W'(0), 32'h0); memModel[0] = '0;
    fRead(A_CTRL, d); check("R8 host request cleared by word 0", d, 32'h1);
    hRead(A_CTRL, d); check("R8 host control after consume", d, 32'h0);

    // R10 fw acknowledge and request
    fWrite(A_FCNT, 32'h0001_0000); fcntModel = 32'h0001_0000;
    check("R10 hostIrq on fw counter change", {31'h0, lastHostIrq}, 32'h1);
    hRead(A_FCNT, d); check("R6 host reads fw counter", d, 32'h0001_0000);
    fWrite(A_CTRL, 32'h2);
    check("R10 hostIrq on fw request rise", {31'h0, lastHostIrq}, 32'h1);
    hRead(A_CTRL, d); check("R5 host sees fw request", d, 32'h4);

    // R11 mask
    fWrite(A_MASK, 32'hFFFF_FFFF);
    hRead(A_MASK, d); check("R11 fw mask write ignored", d, 32'h0);
    hWrite(A_MASK, 32'hFFFF_0000); maskModel = 32'hFFFF_0000;
    check("R11 mask write raises no irq", {30'h0, lastFwIrq, lastHostIrq}, 32'h0);
    fRead(A_MASK, d); check("R11 fw reads mask", d, 32'hFFFF_0000);
    fWrite(A_FCNT, 32'h0001_0001); fcntModel = 32'h0001_0001;
    check("R10 hostIrq masked", {31'h0, lastHostIrq}, 32'h0);
    hWrite(A_HCNT, 32'h0001_0001); hcntModel = 32'h0001_0001;
    check("R9 fwIrq unmasked", {31'h0, lastFwIrq}, 32'h1);

    // R3 simultaneous claim on a free mailbox
    bothWrite(1'b1, A_CTRL, 32'h1, 1'b1, A_CTRL, 32'h1);
    hRead(A_CTRL, d); check("R3 host wins tie", d & 32'h1, 32'h1);
    fRead(A_CTRL, d); check("R3 fw loses tie", d & 32'h1, 32'h0);
    hWrite(A_CTRL, 32'h0);
    hRead(A_CTRL, d); check("R4 owner clears lock", d & 32'h1, 32'h0);

    // R7 same-word collision
    bothWrite(1'b1, ADDR_W'(3), 32'hAAAA_0003, 1'b1, ADDR_W'(3), 32'h5555_0003);
    memModel[3] = 32'hAAAA_0003;
    fRead(ADDR_W'(3), d); check("R7 host wins same-word write", d, 32'hAAAA_0003);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] v;
      int idx;
      op = int'($urandom % 5);
      idx = int'($urandom % MEM_WORDS);
      v = (($urandom % 2) == 0) ? ($urandom & 32'h3) : $urandom;
      case (op)
        0: begin hWrite(ADDR_W'(idx), v); memModel[idx] = v; end
        1: begin fWrite(ADDR_W'(idx), v); memModel[idx] = v; end
        2: begin
          hWrite(A_HCNT, v);
          check("R9 random host counter irq", {31'h0, lastFwIrq},
                {31'h0, expCntIrq(hcntModel, v, maskModel[1])});
          hcntModel = v;
        end
        3: begin
          fWrite(A_FCNT, v);
          check("R10 random fw counter irq", {31'h0, lastHostIrq},
                {31'h0, expCntIrq(fcntModel, v, maskModel[17])});
          fcntModel = v;
        end
        default: begin
          hWrite(A_MASK, v); maskModel = v;
          check("R11 random mask write no irq", {30'h0, lastFwIrq, lastHostIrq}, 32'h0);
        end
      endcase
      if (op <= 1) begin
        hRead(ADDR_W'(idx), d); check("R7 random host read", d, memModel[idx]);
        fRead(ADDR_W'(idx), d); check("R7 random fw read", d, memModel[idx]);
      end else begin
        fRead(A_HCNT, d); check("R6 random host counter", d, hcntModel);
        hRead(A_FCNT, d); check("R6 random fw counter", d, fcntModel);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule